// File: doc/BRIEF.md
# Lockstep Multi-Lane Conditional Row Accumulator

This block reduces the rows of a 16-row byte matrix held in an external memory. It works on `LANES` rows at once. All lanes share one controller and walk the same column index `j` in lockstep.

For each element, a lane first decides whether its running sum is still below a threshold of 10. It then forms a speculative sum. The lane keeps that speculative sum only when the threshold test passed; otherwise the old sum stays. The column count `k` is supplied at run time and is the same for every row.

After the last column, each lane's sum is divided by `k` on one shared serial divider. The quotients are sent out as results, one per row, with the result address equal to the row number.

Elements are fetched through two fixed-latency read ports. Each lane issues its own scalar read at address `row*k + j`. Reads are packed two per cycle in lane order. The result port is a valid/ready stream. Once `res_valid` is raised, `res_addr` and `res_data` hold still until `res_ready` is seen high at a clock edge, and the controller makes no progress while it waits. A one-cycle `done` pulse closes each run.

Top module: `rowacc_top`

## Requirements
- R1: During reset and in the first cycle after it, `done`, `res_valid`, `rd_en_a` and `rd_en_b` are all low.
- R2: A run started with `start` emits exactly 16 results, one per row. They go out in ascending row order, and each result carries its row number on `res_addr`.
- R3: Each row's sum begins at 0. The row's elements are visited for j = 0 .. k-1. An element is added only when the sum before it is below 10. The result is floor(sum / k).
- R4: The element for row r and column j is read at address r*k + j. Lane 2g always uses port A and lane 2g+1 always uses port B. Lanes of a step hold rows base .. base+LANES-1.
- R5: Port B never reads without port A in the same cycle. A run with k > 0 has exactly (16/LANES)·k·ceil(LANES/2) read cycles.
- R6: With k = 0 no read is issued, and every row's result is 0.
- R7: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_addr` and `res_data` keep their values into the next cycle.
- R8: `done` is high for exactly one cycle. That cycle directly follows the handshake of the 16th result.
- R9: The controller samples `k_in` only when it accepts `start` while idle. A `start` or `k_in` change during a run, or in the `done` cycle, has no effect: no extra results, no extra reads, and the results keep the value of k sampled at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; accepted only while idle |
| k_in | input | KW | Column count per row, sampled at start |
| done | output | 1 | One-cycle pulse after the final result |
| rd_en_a | output | 1 | Read request on port A |
| rd_addr_a | output | AW | Element address on port A |
| rd_data_a | input | EW | Port A read data, LAT cycles after the request |
| rd_en_b | output | 1 | Read request on port B |
| rd_addr_b | output | AW | Element address on port B |
| rd_data_b | input | EW | Port B read data, LAT cycles after the request |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result sink accepts |
| res_addr | output | RW | Row number of the offered result |
| res_data | output | DW | Quotient of the row sum by k |

## Verification
Two events can meet in one cycle: the `done` pulse and a fresh `start` request. The bench waits until it sees `done` high, then raises `start` in that same cycle. A correct design must ignore this request. The bench judges this by confirming that no read or result appears in the following cycles.

A second overlap is result back-pressure on the last lane of the last step, which lands exactly where the controller decides to finish. Random stalls on `res_ready` are used to hit it, and the bench then checks that `done` arrives exactly one cycle after the final accepted handshake.

// File: rtl/rowacc_pkg.sv
package rowacc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_INIT, ST_CMP, ST_LOAD, ST_WAIT, ST_ADD,
    ST_SEL, ST_DIVGO, ST_DIVRUN, ST_WRITE, ST_DONE
  } acc_state_e;
endpackage

// File: rtl/rowacc_lane.sv
module rowacc_lane #(
  parameter int EW    = 8,
  parameter int DW    = 16,
  parameter int LIMIT = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cmp_en,
  input  logic          ld_en,
  input  logic [EW-1:0] ld_data,
  input  logic          add_en,
  input  logic          sel_en,
  output logic [DW-1:0] sum
);
  logic          flag_r;
  logic [DW-1:0] spec_r;
  logic [EW-1:0] elem_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum    <= '0;
      flag_r <= 1'b0;
      spec_r <= '0;
      elem_r <= '0;
    end else begin
      if (clr) sum <= '0;
      else if (sel_en && flag_r) sum <= spec_r;
      if (cmp_en) flag_r <= (sum < DW'(LIMIT));
      if (ld_en)  elem_r <= ld_data;
      if (add_en) spec_r <= sum + DW'(elem_r);
    end
  end
endmodule

// File: rtl/rowacc_div.sv
module rowacc_div #(
  parameter int DW = 16,
  parameter int KW = 8,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [KW-1:0] divisor,
  output logic [DW-1:0] quot,
  output logic          done
);
  logic [DW-1:0] q_r;
  logic [KW-1:0] rem_r, dvs_r;
  logic [CW-1:0] cnt_r;
  logic          busy_r;
  logic [KW:0]   rem_sh;
  logic          fits;

  assign rem_sh = {rem_r, q_r[DW-1]};
  assign fits   = rem_sh >= {1'b0, dvs_r};
  assign quot   = q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r    <= '0;
      rem_r  <= '0;
      dvs_r  <= '0;
      cnt_r  <= '0;
      busy_r <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q_r    <= dividend;
        rem_r  <= '0;
        dvs_r  <= divisor;
        cnt_r  <= CW'(DW);
        busy_r <= 1'b1;
      end else if (busy_r) begin
        q_r   <= {q_r[DW-2:0], fits};
        rem_r <= fits ? KW'(rem_sh - {1'b0, dvs_r}) : rem_sh[KW-1:0];
        cnt_r <= cnt_r - 1'b1;
        if (cnt_r == CW'(1)) begin
          busy_r <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rowacc_top.sv
module rowacc_top #(
  parameter int LANES = 2,
  parameter int ROWS  = 16,
  parameter int KW    = 8,
  parameter int EW    = 8,
  parameter int DW    = 16,
  parameter int LAT   = 2,
  parameter int LIMIT = 10,
  localparam int RW   = $clog2(ROWS),
  localparam int AW   = RW + 1 + KW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] k_in,
  output logic          done,
  output logic          rd_en_a,
  output logic [AW-1:0] rd_addr_a,
  input  logic [EW-1:0] rd_data_a,
  output logic          rd_en_b,
  output logic [AW-1:0] rd_addr_b,
  input  logic [EW-1:0] rd_data_b,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [RW-1:0] res_addr,
  output logic [DW-1:0] res_data
);
  import rowacc_pkg::*;

  localparam int G  = (LANES + 1) / 2;
  localparam int GW = (G > 1) ? $clog2(G) : 1;
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int AR = $clog2(LANES + 1);

  acc_state_e    st;
  logic [KW-1:0] kq, j_r;
  logic [RW:0]   base_r;
  logic [GW-1:0] g_r;
  logic [LW-1:0] li_r;
  logic [AR-1:0] arr_r;
  logic [DW-1:0] resq_r;
  logic [LAT-1:0] pa_v, pb_v;
  logic [LW-1:0] pa_l [LAT];
  logic [LW-1:0] pb_l [LAT];
  logic [DW-1:0] lane_sum [LANES];
  logic [DW-1:0] div_q;
  logic          div_done;
  logic [RW:0]   row_a, row_b;
  logic          b_ok;

  // Scalarised loads: two lanes per cycle, in lane order
  assign row_a     = base_r + (RW+1)'({g_r, 1'b0});
  assign row_b     = base_r + (RW+1)'({g_r, 1'b1});
  assign b_ok      = int'({g_r, 1'b1}) < LANES;
  assign rd_en_a   = (st == ST_LOAD);
  assign rd_en_b   = rd_en_a && b_ok;
  assign rd_addr_a = AW'(row_a) * AW'(kq) + AW'(j_r);
  assign rd_addr_b = AW'(row_b) * AW'(kq) + AW'(j_r);

  assign done      = (st == ST_DONE);
  assign res_valid = (st == ST_WRITE);
  assign res_addr  = RW'(base_r + (RW+1)'(li_r));
  assign res_data  = resq_r;

  // Lane tags travel with each read for the fixed memory latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_v <= '0;
      pb_v <= '0;
      for (int i = 0; i < LAT; i++) begin
        pa_l[i] <= '0;
        pb_l[i] <= '0;
      end
    end else begin
      pa_v[0] <= rd_en_a;
      pb_v[0] <= rd_en_b;
      pa_l[0] <= LW'({g_r, 1'b0});
      pb_l[0] <= LW'({g_r, 1'b1});
      for (int i = 1; i < LAT; i++) begin
        pa_v[i] <= pa_v[i-1];
        pb_v[i] <= pb_v[i-1];
        pa_l[i] <= pa_l[i-1];
        pb_l[i] <= pb_l[i-1];
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic hit_a, hit_b;
    assign hit_a = pa_v[LAT-1] && (pa_l[LAT-1] == LW'(l));
    assign hit_b = pb_v[LAT-1] && (pb_l[LAT-1] == LW'(l));
    rowacc_lane #(.EW(EW), .DW(DW), .LIMIT(LIMIT)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (st == ST_INIT),
      .cmp_en  (st == ST_CMP),
      .ld_en   (hit_a || hit_b),
      .ld_data (hit_a ? rd_data_a : rd_data_b),
      .add_en  (st == ST_ADD),
      .sel_en  (st == ST_SEL),
      .sum     (lane_sum[l])
    );
  end

  rowacc_div #(.DW(DW), .KW(KW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (st == ST_DIVGO),
    .dividend (lane_sum[li_r]),
    .divisor  (kq),
    .quot     (div_q),
    .done     (div_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      kq     <= '0;
      j_r    <= '0;
      base_r <= '0;
      g_r    <= '0;
      li_r   <= '0;
      arr_r  <= '0;
      resq_r <= '0;
    end else begin
      if (st == ST_CMP) arr_r <= '0;
      else arr_r <= arr_r + AR'(pa_v[LAT-1]) + AR'(pb_v[LAT-1]);
      case (st)
        ST_IDLE: if (start) begin
          kq     <= k_in;
          base_r <= '0;
          st     <= ST_INIT;
        end
        ST_INIT: begin
          j_r  <= '0;
          li_r <= '0;
          if (kq == '0) begin
            resq_r <= '0;
            st     <= ST_WRITE;
          end else st <= ST_CMP;
        end
        ST_CMP: begin
          g_r <= '0;
          st  <= ST_LOAD;
        end
        ST_LOAD: if (g_r == GW'(G - 1)) st <= ST_WAIT;
                 else g_r <= g_r + 1'b1;
        ST_WAIT: if (arr_r == AR'(LANES)) st <= ST_ADD;
        ST_ADD: begin
          j_r <= j_r + 1'b1;
          st  <= ST_SEL;
        end
        ST_SEL:   st <= (j_r == kq) ? ST_DIVGO : ST_CMP;
        ST_DIVGO: st <= ST_DIVRUN;
        ST_DIVRUN: if (div_done) begin
          resq_r <= div_q;
          st     <= ST_WRITE;
        end
        ST_WRITE: if (res_ready) begin
          if (li_r == LW'(LANES - 1)) begin
            if (base_r + (RW+1)'(LANES) < (RW+1)'(ROWS)) begin
              base_r <= base_r + (RW+1)'(LANES);
              st     <= ST_INIT;
            end else st <= ST_DONE;
          end else begin
            li_r <= li_r + 1'b1;
            st   <= (kq == '0) ? ST_WRITE : ST_DIVGO;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rowacc_chk.sv
module rowacc_chk #(
  parameter int RW = 4,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          rd_en_a,
  input logic          rd_en_b,
  input logic          res_valid,
  input logic          res_ready,
  input logic [RW-1:0] res_addr,
  input logic [DW-1:0] res_data
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!done && !res_valid && !rd_en_a && !rd_en_b));

  p_port_pairing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_b |-> rd_en_a);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_addr) && $stable(res_data)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(res_valid && res_ready));
endmodule

bind rowacc_top rowacc_chk #(.RW(RW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .rd_en_a   (rd_en_a),
  .rd_en_b   (rd_en_b),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_addr  (res_addr),
  .res_data  (res_data)
);

// File: tb/tb_rowacc_top.sv
`timescale 1ns/1ps
module tb_rowacc_top;
  localparam int LANES = 2;
  localparam int ROWS  = 16;
  localparam int KW    = 8;
  localparam int EW    = 8;
  localparam int DW    = 16;
  localparam int LAT   = 2;
  localparam int RW    = $clog2(ROWS);
  localparam int AW    = RW + 1 + KW;
  localparam int G     = (LANES + 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [KW-1:0] k_in = '0;
  logic res_ready = 1'b1;
  logic done, rd_en_a, rd_en_b, res_valid;
  logic [AW-1:0] rd_addr_a, rd_addr_b;
  logic [EW-1:0] rd_data_a, rd_data_b;
  logic [RW-1:0] res_addr;
  logic [DW-1:0] res_data;

  always #4 clk = ~clk;

  rowacc_top #(.LANES(LANES), .ROWS(ROWS), .KW(KW), .EW(EW), .DW(DW), .LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .k_in(k_in), .done(done),
    .rd_en_a(rd_en_a), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_en_b(rd_en_b), .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_addr(res_addr), .res_data(res_data)
  );

  int checks = 0, errors = 0, cyc = 0, ncyc = 0;
  logic [EW-1:0] mem [1 << AW];
  int exp_res [ROWS];
  int wr_cnt, rdcyc, rd_bad, rs, rj, rg, cur_k, done_cnt, last_hs;
  bit bp_mode = 1'b0;
  logic [AW-1:0] qa_addr = '0, qb_addr = '0;
  logic [EW-1:0] pipa [LAT];
  logic [EW-1:0] pipb [LAT];
  logic pv = 1'b0, pr = 1'b0;
  logic [RW-1:0] paddr;
  logic [DW-1:0] pdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Fixed-latency memory model
  always @(negedge clk) begin
    qa_addr = rd_addr_a;
    qb_addr = rd_addr_b;
  end
  always @(posedge clk) begin
    pipa[0] <= mem[qa_addr];
    pipb[0] <= mem[qb_addr];
    for (int i = 1; i < LAT; i++) begin
      pipa[i] <= pipa[i-1];
      pipb[i] <= pipb[i-1];
    end
  end
  assign rd_data_a = pipa[LAT-1];
  assign rd_data_b = pipb[LAT-1];

  always @(posedge clk) begin
    #1;
    res_ready = bp_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Port monitor
  always @(negedge clk) begin
    ncyc++;
    if (rst_n) begin
      if (rd_en_a) begin
        int ea;
        bit eb;
        rdcyc++;
        ea = (rs * LANES + 2 * rg) * cur_k + rj;
        eb = (2 * rg + 1) < LANES;
        if (int'(rd_addr_a) != ea) rd_bad++;
        if (rd_en_b != eb) rd_bad++;
        if (eb && int'(rd_addr_b) != ea + cur_k) rd_bad++;
        rg++;
        if (rg == G) begin
          rg = 0;
          rj++;
          if (rj == cur_k) begin
            rj = 0;
            rs++;
          end
        end
      end else if (rd_en_b) rd_bad++;
      if (pv && !pr)
        chk(res_valid && res_addr == paddr && res_data == pdata, "R7",
            "held result data", int'(res_data), int'(pdata));
      if (res_valid && res_ready) begin
        if (wr_cnt < ROWS) begin
          chk(int'(res_addr) == wr_cnt, "R2", "result address", int'(res_addr), wr_cnt);
          chk(int'(res_data) == exp_res[wr_cnt], (cur_k == 0) ? "R6" : "R3",
              "row result", int'(res_data), exp_res[wr_cnt]);
        end
        wr_cnt++;
        last_hs = ncyc;
      end
      if (done) begin
        done_cnt++;
        chk(last_hs == ncyc - 1 && wr_cnt == ROWS, "R8", "done after last handshake",
            ncyc - last_hs, 1);
      end
      pv = res_valid;
      pr = res_ready;
      paddr = res_addr;
      pdata = res_data;
    end
  end

  task automatic run(input int k, input int fill, input bit bp, input bit mid,
                     input bit at_done);
    int exp_rd, rd_snap;
    for (int a = 0; a < (1 << AW); a++) begin
      case (fill)
        0: mem[a] = EW'($urandom_range(0, 255));
        1: mem[a] = EW'($urandom_range(0, 3));
        2: mem[a] = 8'd200;
        default: mem[a] = 8'd3;
      endcase
    end
    for (int r = 0; r < ROWS; r++) begin
      int s = 0;
      for (int j = 0; j < k; j++) if (s < 10) s += int'(mem[r * k + j]);
      exp_res[r] = (k == 0) ? 0 : s / k;
    end
    wr_cnt = 0; rdcyc = 0; rd_bad = 0; rs = 0; rj = 0; rg = 0;
    done_cnt = 0; last_hs = -10; cur_k = k; bp_mode = bp;
    @(posedge clk); #2;
    k_in = KW'(k);
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    if (mid) begin
      repeat (9) @(posedge clk);
      #2;
      start = 1'b1;
      k_in = KW'(k) ^ 8'h5A;
      @(posedge clk); #2;
      start = 1'b0;
    end
    @(negedge clk);
    while (done !== 1'b1) @(negedge clk);
    if (at_done) start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    rd_snap = rdcyc;
    repeat (12) @(posedge clk);
    #2;
    exp_rd = (k == 0) ? 0 : (ROWS / LANES) * k * G;
    chk(wr_cnt == ROWS, "R2", "result count", wr_cnt, ROWS);
    chk(rd_bad == 0, "R4", "read address mismatches", rd_bad, 0);
    if (k == 0) chk(rdcyc == 0, "R6", "read cycles with k=0", rdcyc, 0);
    else chk(rdcyc == exp_rd, "R5", "read cycles", rdcyc, exp_rd);
    chk(rdcyc == rd_snap && done_cnt == 1, "R9", "activity after done",
        rdcyc - rd_snap + done_cnt, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!done && !res_valid && !rd_en_a && !rd_en_b, "R1", "outputs in reset",
        int'({done, res_valid, rd_en_a, rd_en_b}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !res_valid && !rd_en_a && !rd_en_b, "R1", "outputs after reset",
        int'({done, res_valid, rd_en_a, rd_en_b}), 0);
    run(1, 0, 1'b0, 1'b0, 1'b0);     // R3 single column
    run(0, 0, 1'b1, 1'b0, 1'b1);     // R6 empty rows, start in done cycle (R9)
    run(5, 1, 1'b1, 1'b0, 1'b0);     // R3 predicate on small values
    run(4, 2, 1'b0, 1'b0, 1'b1);     // R3 first element crosses threshold
    run(7, 0, 1'b1, 1'b1, 1'b0);     // R9 start and k change mid-run
    run(12, 3, 1'b1, 1'b0, 1'b0);    // R3 sum stops at 12
    run(255, 0, 1'b0, 1'b0, 1'b0);   // R4 largest k
    for (int n = 0; n < 6; n++)
      run($urandom_range(1, 20), $urandom_range(0, 3), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule